// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block holds the pending and enable state of a small group of interrupt sources and, when the processor asks, returns the offset of the vector slot that belongs to the request that should be serviced. It has six maskable sources: an external input, an idle timer, a general timer, a serial port, a memory-write-complete event and a port wakeup. It also has a software trap that cannot be masked. A hardware event sets a maskable source's pending flag. Software clears that flag. A source can win only when its own enable bit and the global enable are both set.

The software trap has its own pending flag. That flag does not appear on the readable pending bus, and it is cleared when a lookup selects the trap. The processor pulses a lookup strobe, and the arbiter then registers an even byte offset in the window 0xE0 to 0xFE. The trap uses 0xFE. Its two-byte slot holds the handler address, high byte first. When no request qualifies, the arbiter returns 0xE0.

Top module: `irq_vec_arb`

## Requirements
- R1: After reset, all pending flags, enable bits, the global enable and the trap flag are 0, and `vec_off_o` is 0xE0.
- R2: When `evt_i[k]` is high, `pend_o[k]` is 1 in the next cycle, whatever the enable bits and the global enable hold.
- R3: When `pend_clr_i[k]` is high, `pend_o[k]` is 0 in the next cycle, unless `evt_i[k]` is high in the same cycle. In that case the flag is 1.
- R4: `en_wr_i` loads `en_i` and `gie_wr_i` loads `gie_i`. A maskable source is active only when its pending flag, its enable bit and the global enable are all 1.
- R5: Bit k of the source buses maps to the slot offset 0xFC - 2k. Bit 0 is the external input, bit 1 the idle timer, bit 2 the general timer, bit 3 the serial port, bit 4 memory write complete and bit 5 port wakeup. The lowest-numbered active bit wins.
- R6: A pending software trap wins over every other source and gives 0xFE, even when the global enable and all enable bits are 0. Its flag has no bit on `pend_o`.
- R7: A lookup that selects the trap clears the trap flag. If `trap_i` is high in that same cycle, the flag stays set.
- R8: When the trap is not pending and no maskable source is active, a lookup gives 0xE0.
- R9: `vec_off_o` changes only in the cycle after a `lookup_i` strobe. There it holds the offset chosen from the state in the strobe cycle.
- R10: `vec_off_o` is always even and lies within 0xE0..0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Interrupt condition per maskable source; sets the pending flag |
| pend_clr_i | input | 6 | Software clear per pending flag |
| en_wr_i | input | 1 | Load strobe for the enable bits |
| en_i | input | 6 | New enable bits |
| gie_wr_i | input | 1 | Load strobe for the global enable |
| gie_i | input | 1 | New global enable value |
| trap_i | input | 1 | Software trap event |
| lookup_i | input | 1 | Lookup strobe from the processor |
| pend_o | output | 6 | Readable pending flags of the maskable sources |
| vec_off_o | output | 8 | Latched vector slot offset |

## Verification
Several properties are checked on every cycle: the set, clear and set-over-clear behaviour of the pending flags, the rule that the output holds between strobes, and the even, in-window offset. Further per-cycle checks cover the trap winning, the trap flag clearing after it is served, and the default offset when the global enable is 0. The exact priority order needs the bench's scenarios, because the winner depends on the full combination of pending and enable bits. Those scenarios sweep every pending pattern against every enable pattern, with the global enable both on and off. The bench also runs the collision cases and the reset-state checks.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam logic [7:0] VEC_TOP  = 8'hFE;
  localparam logic [7:0] VEC_BASE = 8'hE0;

  // slot for maskable source idx: one step below the trap per index
  function automatic logic [7:0] slot_off(input int unsigned idx);
    return VEC_TOP - 8'((idx + 1) * 2);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_trap_flag.sv
module irq_trap_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic take_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (take_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 6,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  act_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // lowest index has the highest priority
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
#(
  parameter int unsigned N = 6  // at most 14 maskable slots fit the window
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] pend_clr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_wr_i,
  input  logic         gie_i,
  input  logic         trap_i,
  input  logic         lookup_i,
  output logic [N-1:0] pend_o,
  output logic [7:0]   vec_off_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  en_q;
  logic          gie_q;
  logic          trap_q;
  logic [N-1:0]  act;
  logic          hit;
  logic [IW-1:0] idx;
  logic [7:0]    off_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (en_wr_i)  en_q  <= en_i;
      if (gie_wr_i) gie_q <= gie_i;
    end
  end

  irq_pend_bank #(.N(N)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (pend_clr_i),
    .q_o   (pend_o)
  );

  irq_trap_flag u_trap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (trap_i),
    .take_i(lookup_i),  // trap always wins when pending
    .q_o   (trap_q)
  );

  assign act = pend_o & en_q & {N{gie_q}};

  irq_prio_enc #(.N(N)) u_enc (
    .act_i(act),
    .hit_o(hit),
    .idx_o(idx)
  );

  always_comb begin
    if (trap_q)   off_d = VEC_TOP;
    else if (hit) off_d = slot_off(32'(idx));
    else          off_d = VEC_BASE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vec_off_o <= VEC_BASE;
    else if (lookup_i) vec_off_o <= off_d;
  end
endmodule

// File: rtl/irq_vec_arb_chk.sv
module irq_vec_arb_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] evt_i,
  input logic [N-1:0] pend_clr_i,
  input logic         trap_i,
  input logic         lookup_i,
  input logic         gie_q,
  input logic         trap_q,
  input logic [N-1:0] pend_o,
  input logic [7:0]   vec_off_o
);
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R2

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_clr_i & ~evt_i)) |=> ((pend_o & $past(pend_clr_i & ~evt_i)) == '0)); // R3

  AST_NO_GIE_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && !gie_q && !trap_q) |=> (vec_off_o == VEC_BASE)); // R4

  AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && trap_q) |=> (vec_off_o == VEC_TOP)); // R6

  AST_TRAP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && trap_q && !trap_i) |=> !trap_q); // R7

  AST_TRAP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> trap_q); // R7

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> $stable(vec_off_o)); // R9

  AST_OFF_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_off_o[0] == 1'b0) && (vec_off_o >= VEC_BASE)); // R10
endmodule

bind irq_vec_arb irq_vec_arb_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .pend_clr_i(pend_clr_i),
  .trap_i    (trap_i),
  .lookup_i  (lookup_i),
  .gie_q     (gie_q),
  .trap_q    (trap_q),
  .pend_o    (pend_o),
  .vec_off_o (vec_off_o)
);

// File: tb/sim_irq_vec_arb.sv
module sim_irq_vec_arb;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0, clr = '0, en = '0;
  logic         en_wr = 1'b0, gie_wr = 1'b0, gie = 1'b0, trap = 1'b0, lookup = 1'b0;
  logic [N-1:0] pend;
  logic [7:0]   off;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  irq_vec_arb #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .pend_clr_i(clr),
    .en_wr_i(en_wr), .en_i(en), .gie_wr_i(gie_wr), .gie_i(gie),
    .trap_i(trap), .lookup_i(lookup), .pend_o(pend), .vec_off_o(off)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_off(input logic [N-1:0] a);
    for (int k = 0; k < N; k++)
      if (a[k]) return 8'hFC - 8'(2 * k);
    return 8'hE0;
  endfunction

  task automatic idle();
    evt = '0; clr = '0; en_wr = 1'b0; gie_wr = 1'b0; trap = 1'b0; lookup = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pend", 8'(pend), 8'h00);
    chk("R1 off", off, 8'hE0);
    evt = '1; step(); idle();
    lookup = 1'b1; step(); idle();
    chk("R1 enables cleared", off, 8'hE0);

    // R3 clear alone and clear vs event
    clr = '1; evt = 6'b000101; step(); idle();
    chk("R3 set wins over clear", 8'(pend), 8'h05);
    clr = 6'b000001; step(); idle();
    chk("R3 clear", 8'(pend), 8'h04);
    clr = '1; step(); idle();

    // R9 hold without lookup
    en_wr = 1'b1; en = '1; gie_wr = 1'b1; gie = 1'b1; evt = 6'b000001; step(); idle();
    step();
    chk("R9 hold", off, 8'hE0);
    lookup = 1'b1; step(); idle();
    chk("R9 latch", off, 8'hFC);
    clr = '1; step(); idle();

    // R6 trap with masks off, R7 collision and clearing
    en_wr = 1'b1; en = '0; gie_wr = 1'b1; gie = 1'b0; trap = 1'b1; step(); idle();
    chk("R6 trap not on pend", 8'(pend), 8'h00);
    lookup = 1'b1; trap = 1'b1; step(); idle();
    chk("R6 trap wins", off, 8'hFE);
    lookup = 1'b1; step(); idle();
    chk("R7 trap kept on collision", off, 8'hFE);
    lookup = 1'b1; step(); idle();
    chk("R7 trap cleared", off, 8'hE0);
    // R6 trap over active maskable
    en_wr = 1'b1; en = '1; gie_wr = 1'b1; gie = 1'b1; evt = '1; trap = 1'b1; step(); idle();
    lookup = 1'b1; step(); idle();
    chk("R6 trap over maskable", off, 8'hFE);
    lookup = 1'b1; step(); idle();
    chk("R5 after trap", off, 8'hFC);
    clr = '1; step(); idle();

    // R2 R4 R5 R8 R10 sweep
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < (1 << N); e++) begin
        for (int p = 0; p < (1 << N); p++) begin
          en_wr = 1'b1; en = N'(e); gie_wr = 1'b1; gie = g[0]; clr = '1; step(); idle();
          evt = N'(p); step(); idle();
          chk("R2 pend", 8'(pend), 8'(p));
          lookup = 1'b1; step(); idle();
          chk(g ? "R5 R8 offset" : "R4 gie gates", off,
              expect_off(N'(p) & N'(e) & {N{g[0]}}));
          chk("R10 even", 8'(off[0]), 8'h00);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule